// File: doc/BRIEF.md
# Synchronizable Multi-Channel Timer Group

This block holds six 16-bit up-counters behind one small register bus. Each channel has its own counter, compare value, clear-source selector and compare output pin. A shared count-enable strobe advances every running channel by one. A run register holds one bit per channel that starts or halts that counter. A group register holds one bit per channel that makes that channel a member of a synchronized group.

While at least two channels are members, a software write to the counter of any member loads the same value into every member. A member whose own compare match clears its counter also sends a group clear. Members that select the group-clear source then restart from zero in the same cycle. A single member on its own behaves as an independent channel.

A compare match toggles the channel's output level. Halting a channel freezes both its count and its output level. Writing the control word of a halted channel forces the output level to the initial level held in that word.

Top module: `sync_timer_group`

## Requirements
- R1: A channel whose run bit is 1 increments its counter by one, wrapping at 16 bits, on every clock edge where `cnt_en` is 1. The run register is at address 0x00, and bit n is the run bit of channel n.
- R2: A channel whose run bit is 0 keeps its counter value, whatever `cnt_en` does, until software writes that counter.
- R3: Halting a channel keeps its output pin at the level the last compare match left it.
- R4: A compare match happens when a running channel sees `cnt_en` while its counter equals its compare value. Each match toggles the output level. The clear-source field is control bits 2:0. With code 001 the counter restarts at 0 after a match. With code 000, and with any code other than 001 and 011, the counter keeps counting.
- R5: The control word holds the clear source in bits 2:0, the output enable in bit 3 and the initial level in bit 4. The pin is the output level ANDed with the output enable. A control write to a halted channel sets the output level to bit 4 on the next edge. A control write to a running channel leaves the level unchanged.
- R6: The group register is at address 0x01 and resets to 0. Bits 5:0 are stored, and every bit above bit 5 reads back as 0 whatever was written.
- R7: While two or more group bits are set, a write to the counter of a member loads the written value into the counter of every member on the same edge. Non-members keep their values.
- R8: While two or more group bits are set, a running member with clear source 011 restarts at 0 on the edge where another member restarts through its own clear-source 001 match. Running non-members with code 011 are not affected.
- R9: With fewer than two group bits set, a counter write loads only the addressed channel, and no group clear occurs.
- R10: A counter write takes priority over counting in the same cycle. A clear takes priority over counting in the same cycle.
- R11: After reset all counters, compare values, control words, the run register and the group register read 0, and all output pins are 0. Channel n occupies addresses 8+4n (counter), 9+4n (compare) and 10+4n (control).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Shared count strobe |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| tout | output | 6 | Compare output pins, one per channel |

## Verification
The bench sweeps compare values 0 to 4 through one strobe run and predicts counter phase and pin level arithmetically. An off-by-one match test or a missing restart would shift both values. It loads members with distinct values before a group preset, so a preset leaking to non-members, or one applied while only one group bit is set, shows up as a changed value. It clears a member through a partner's match while a non-member with the same clear source keeps counting, which exposes a clear that ignores membership. It also writes a counter while the strobe is high, so a design that lets counting win would read one too high.

// File: rtl/stg_pkg.sv
package stg_pkg;
    localparam logic [2:0] CLR_NONE = 3'b000;
    localparam logic [2:0] CLR_OWN  = 3'b001;
    localparam logic [2:0] CLR_GRP  = 3'b011;

    localparam logic [1:0] FLD_CNT = 2'd0;
    localparam logic [1:0] FLD_CMP = 2'd1;
    localparam logic [1:0] FLD_CTL = 2'd2;

    localparam int ADDR_RUN  = 0;
    localparam int ADDR_GRP  = 1;
    localparam int SLOT_BASE = 2;
endpackage

// File: rtl/stg_group_ctl.sv
module stg_group_ctl #(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0] grp_bits,
    input  logic [NCH-1:0] own_clr,
    output logic [NCH-1:0] member,
    output logic           grp_clr
);
    logic active;

    always_comb begin
        active  = ($countones(grp_bits) >= 2);
        member  = active ? grp_bits : '0;
        grp_clr = |(own_clr & member);
    end
endmodule

// File: rtl/stg_channel.sv
module stg_channel
    import stg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          run,
    input  logic          member,
    input  logic          load,
    input  logic          cmp_we,
    input  logic          ctl_we,
    input  logic [CW-1:0] wdata,
    input  logic          grp_clr,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmp_o,
    output logic [4:0]    ctl_o,
    output logic          own_clr_o,
    output logic          tout_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
        logic [2:0]    src;
        logic          oe;
        logic          init;
        logic          lvl;
    } ch_state_t;

    ch_state_t state_d, state_q;
    logic counting, match, grp_hit;

    always_comb begin
        state_d   = state_q;
        counting  = run & cnt_en & ~load;
        match     = counting && (state_q.cnt == state_q.cmp);
        own_clr_o = match && (state_q.src == CLR_OWN);
        grp_hit   = member && run && grp_clr && (state_q.src == CLR_GRP);

        if (load) begin
            state_d.cnt = wdata;
        end else if (own_clr_o || grp_hit) begin
            state_d.cnt = '0;
        end else if (counting) begin
            state_d.cnt = state_q.cnt + CW'(1);
        end

        if (match) begin
            state_d.lvl = ~state_q.lvl;
        end
        if (cmp_we) begin
            state_d.cmp = wdata;
        end
        if (ctl_we) begin
            state_d.src  = wdata[2:0];
            state_d.oe   = wdata[3];
            state_d.init = wdata[4];
            if (!run) begin
                state_d.lvl = wdata[4];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt_o  = state_q.cnt;
    assign cmp_o  = state_q.cmp;
    assign ctl_o  = {state_q.init, state_q.oe, state_q.src};
    assign tout_o = state_q.lvl & state_q.oe;
endmodule

// File: rtl/stg_read_mux.sv
module stg_read_mux
    import stg_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic [AW-1:0]          addr,
    input  logic [NCH-1:0]         run_bits,
    input  logic [NCH-1:0]         grp_bits,
    input  logic [NCH-1:0][CW-1:0] cnt_all,
    input  logic [NCH-1:0][CW-1:0] cmp_all,
    input  logic [NCH-1:0][4:0]    ctl_all,
    output logic [CW-1:0]          rdata
);
    localparam int SLOT_W = AW - 2;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        fld;

    always_comb begin
        slot  = addr[AW-1:2];
        fld   = addr[1:0];
        rdata = '0;
        if (addr == AW'(ADDR_RUN)) begin
            rdata = CW'(run_bits);
        end else if (addr == AW'(ADDR_GRP)) begin
            rdata = CW'(grp_bits);
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (slot == SLOT_W'(n + SLOT_BASE)) begin
                    case (fld)
                        FLD_CNT: rdata = cnt_all[n];
                        FLD_CMP: rdata = cmp_all[n];
                        FLD_CTL: rdata = CW'(ctl_all[n]);
                        default: rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/sync_timer_group.sv
module sync_timer_group
    import stg_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NCH-1:0] tout
);
    localparam int SLOT_W = AW - 2;

    typedef struct packed {
        logic [NCH-1:0] run;
        logic [NCH-1:0] grp;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NCH-1:0]         run_vec, sync_vec;
    logic [NCH-1:0]         wr_cnt, wr_cmp, wr_ctl, load, own_clr, member;
    logic                   grp_clr, grp_write;
    logic [NCH-1:0][CW-1:0] cnt_all, cmp_all;
    logic [NCH-1:0][4:0]    ctl_all;

    always_comb begin
        top_d = top_q;
        if (bus_we && bus_addr == AW'(ADDR_RUN)) top_d.run = bus_wdata[NCH-1:0];
        if (bus_we && bus_addr == AW'(ADDR_GRP)) top_d.grp = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign run_vec  = top_q.run;
    assign sync_vec = top_q.grp;

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            wr_cnt[n] = bus_we && (bus_addr[AW-1:2] == SLOT_W'(n + SLOT_BASE))
                        && (bus_addr[1:0] == FLD_CNT);
            wr_cmp[n] = bus_we && (bus_addr[AW-1:2] == SLOT_W'(n + SLOT_BASE))
                        && (bus_addr[1:0] == FLD_CMP);
            wr_ctl[n] = bus_we && (bus_addr[AW-1:2] == SLOT_W'(n + SLOT_BASE))
                        && (bus_addr[1:0] == FLD_CTL);
        end
        grp_write = |(wr_cnt & member);
        load      = wr_cnt | (member & {NCH{grp_write}});
    end

    stg_group_ctl #(.NCH(NCH)) u_grp (
        .grp_bits (sync_vec),
        .own_clr  (own_clr),
        .member   (member),
        .grp_clr  (grp_clr)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        stg_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_en    (cnt_en),
            .run       (run_vec[g]),
            .member    (member[g]),
            .load      (load[g]),
            .cmp_we    (wr_cmp[g]),
            .ctl_we    (wr_ctl[g]),
            .wdata     (bus_wdata),
            .grp_clr   (grp_clr),
            .cnt_o     (cnt_all[g]),
            .cmp_o     (cmp_all[g]),
            .ctl_o     (ctl_all[g]),
            .own_clr_o (own_clr[g]),
            .tout_o    (tout[g])
        );
    end

    stg_read_mux #(.NCH(NCH), .CW(CW), .AW(AW)) u_rd (
        .addr     (bus_addr),
        .run_bits (run_vec),
        .grp_bits (sync_vec),
        .cnt_all  (cnt_all),
        .cmp_all  (cmp_all),
        .ctl_all  (ctl_all),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
    parameter int NCH = 6,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cnt_en,
    input logic                   bus_we,
    input logic [AW-1:0]          bus_addr,
    input logic [CW-1:0]          bus_wdata,
    input logic [CW-1:0]          bus_rdata,
    input logic [NCH-1:0]         tout,
    input logic [NCH-1:0]         run_q,
    input logic [NCH-1:0]         sync_q,
    input logic [NCH-1:0][CW-1:0] cnt_all
);
    logic [NCH-1:0] grp_m;
    assign grp_m = ($countones(sync_q) >= 2) ? sync_q : '0;

    // R6: bits above the stored group bits always read 0
    p_grp_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(1)) |-> ((bus_rdata >> NCH) == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[i] && cnt_en && !bus_we && ($countones(sync_q) < 2))
            |=> ((cnt_all[i] == $past(cnt_all[i]) + CW'(1)) || (cnt_all[i] == '0)));

        p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !bus_we) |=> $stable(cnt_all[i]));

        p_halt_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !bus_we) |=> $stable(tout[i]));

        for (genvar j = 0; j < NCH; j++) begin : g_src
            p_group_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == AW'(8 + 4 * j) && grp_m[j] && grp_m[i])
                |=> (cnt_all[i] == $past(bus_wdata)));
        end
    end
endmodule

bind sync_timer_group stg_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tout      (tout),
    .run_q     (run_vec),
    .sync_q    (sync_vec),
    .cnt_all   (cnt_all)
);

// File: tb/tb_sync_timer_group.sv
module tb_sync_timer_group;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cnt_en = 0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  tout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    sync_timer_group dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tout(tout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [4:0] ch_addr(int n, int f);
        return 5'(8 + 4 * n + f);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic strobe(input int n);
        if (n > 0) begin
            @(negedge clk);
            cnt_en = 1;
            repeat (n) @(negedge clk);
            cnt_en = 0;
        end
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        rd(5'd0, 16'h0, "R11 run reset");
        rd(5'd1, 16'h0, "R6 group reset");
        for (int n = 0; n < NCH; n++) begin
            rd(ch_addr(n, 0), 16'h0, "R11 counter reset");
            rd(ch_addr(n, 2), 16'h0, "R11 control reset");
        end
        chk(16'(tout), 16'h0, "R11 pins reset");

        // R1 / R2: count per channel, then halt
        for (int n = 0; n < NCH; n++) begin
            wr(ch_addr(n, 1), 16'hFFFF);
            wr(5'd0, 16'(1 << n));
            strobe(n * 3 + 2);
            rd(ch_addr(n, 0), 16'(n * 3 + 2), "R1 count");
            wr(5'd0, 16'h0);
            strobe(4);
            rd(ch_addr(n, 0), 16'(n * 3 + 2), "R2 halted hold");
            wr(ch_addr(n, 0), 16'h0);
        end

        // R4 sweep: own-match clear, period cmp+1
        for (int c = 0; c <= 4; c++) begin
            wr(5'd0, 16'h0);
            wr(ch_addr(2, 0), 16'h0);
            wr(ch_addr(2, 1), 16'(c));
            wr(ch_addr(2, 2), 16'h0009);
            wr(5'd0, 16'h0004);
            strobe(11);
            rd(ch_addr(2, 0), 16'(11 % (c + 1)), "R4 restart phase");
            chk(16'(tout[2]), 16'((11 / (c + 1)) & 1), "R4 toggle level");
        end

        // R4 no-clear code keeps counting past match
        wr(5'd0, 16'h0);
        wr(ch_addr(2, 0), 16'h0);
        wr(ch_addr(2, 1), 16'd2);
        wr(ch_addr(2, 2), 16'h0008);
        wr(5'd0, 16'h0004);
        strobe(5);
        rd(ch_addr(2, 0), 16'd5, "R4 no clear count");
        chk(16'(tout[2]), 16'h1, "R4 no clear toggle");

        // R3 halt keeps level
        wr(5'd0, 16'h0);
        strobe(5);
        chk(16'(tout[2]), 16'h1, "R3 level kept when halted");

        // R5 initial level forcing
        wr(ch_addr(4, 2), 16'h0018);
        chk(16'(tout[4]), 16'h1, "R5 force init 1");
        wr(ch_addr(4, 2), 16'h0008);
        chk(16'(tout[4]), 16'h0, "R5 force init 0");
        wr(ch_addr(4, 2), 16'h0010);
        chk(16'(tout[4]), 16'h0, "R5 output enable gate");
        wr(ch_addr(4, 2), 16'h0018);
        chk(16'(tout[4]), 16'h1, "R5 force init 1 again");
        wr(5'd0, 16'h0010);
        wr(ch_addr(4, 2), 16'h0008);
        chk(16'(tout[4]), 16'h1, "R5 running write keeps level");
        wr(5'd0, 16'h0);

        // R6 reserved bits
        wr(5'd1, 16'hFFFF);
        rd(5'd1, 16'h003F, "R6 reserved read 0");
        wr(5'd1, 16'h0);
        rd(5'd1, 16'h0, "R6 clear");

        // R7 group preset
        for (int n = 0; n < NCH; n++) wr(ch_addr(n, 0), 16'(16'h0100 + n));
        wr(5'd1, 16'h001A);
        wr(ch_addr(3, 0), 16'h1234);
        for (int n = 0; n < NCH; n++)
            rd(ch_addr(n, 0), (n == 1 || n == 3 || n == 4) ? 16'h1234 : 16'(16'h0100 + n),
               "R7 group preset");
        wr(ch_addr(1, 0), 16'h0042);
        rd(ch_addr(4, 0), 16'h0042, "R7 preset from other member");
        wr(ch_addr(0, 0), 16'h0077);
        rd(ch_addr(0, 0), 16'h0077, "R7 non-member write");
        rd(ch_addr(3, 0), 16'h0042, "R7 non-member leaves members");

        // R9 single group bit
        wr(5'd1, 16'h0004);
        wr(ch_addr(2, 0), 16'h5555);
        rd(ch_addr(2, 0), 16'h5555, "R9 single bit own load");
        rd(ch_addr(1, 0), 16'h0042, "R9 single bit no spread");

        // R8 group clear
        wr(5'd1, 16'h0);
        for (int n = 0; n < 4; n++) wr(ch_addr(n, 0), 16'h0);
        wr(ch_addr(0, 1), 16'd5);     wr(ch_addr(0, 2), 16'h0001);
        wr(ch_addr(1, 1), 16'hFFFF);  wr(ch_addr(1, 2), 16'h0003);
        wr(ch_addr(2, 1), 16'hFFFF);  wr(ch_addr(2, 2), 16'h0003);
        wr(ch_addr(3, 1), 16'hFFFF);  wr(ch_addr(3, 2), 16'h0000);
        wr(5'd1, 16'h000B);
        wr(5'd0, 16'h000F);
        strobe(6);
        rd(ch_addr(0, 0), 16'd0, "R8 source member restart");
        rd(ch_addr(1, 0), 16'd0, "R8 group clear member");
        rd(ch_addr(2, 0), 16'd6, "R8 non-member unaffected");
        rd(ch_addr(3, 0), 16'd6, "R8 member code 000 unaffected");
        strobe(2);
        rd(ch_addr(1, 0), 16'd2, "R8 member counts after clear");
        rd(ch_addr(2, 0), 16'd8, "R8 non-member continues");

        // R10 preset beats count
        @(negedge clk);
        bus_addr = ch_addr(0, 0); bus_wdata = 16'h0700; bus_we = 1; cnt_en = 1;
        @(negedge clk);
        bus_we = 0; cnt_en = 0;
        rd(ch_addr(0, 0), 16'h0700, "R10 preset over count");
        rd(ch_addr(1, 0), 16'h0700, "R10 group preset over count");
        rd(ch_addr(2, 0), 16'd9, "R10 non-member counted");
        wr(5'd0, 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule